// File: doc/BRIEF.md
# Reciprocal Square Root Estimator

This block gives an approximation of 1/sqrt(x) for a single-precision floating-point operand, fully pipelined. The first approximation needs no table and no iteration. The operand's 32-bit pattern is read as an unsigned integer, shifted right by one place and subtracted from a fixed constant. The integer that results is then read back as a float. A single Newton-Raphson step in floating point sharpens this first approximation, and the refined value is the result.

A producer presents an operand together with a valid flag, at most one per clock. Exactly five cycles later the result leaves with its own valid flag. The datapath holds its own small floating-point multiplier and subtractor. Both truncate instead of rounding. Operands that are zero, denormal, negative, infinite or NaN never enter the estimate path: a fixed result code stands in for them. Nothing raises exception flags.

Top module: `rsqrt_est`

## Requirements
- R1: For every cycle in which `in_valid` is high, `out_valid` goes high exactly five cycles later, and it is high in no other cycle. Back-to-back operands are accepted with no gap, and results come out in the order the operands went in.
- R2: While `rst_n` is low, and in the cycle after it is released, `out_valid` and `out_data` are both 0. Operands presented while reset is low produce no output.
- R3: Any operand whose exponent field (bits 30:23) is 0, that is a zero or a denormal of either sign, is flushed to zero and gives positive infinity, 32'h7F800000.
- R4: An operand with the sign bit (bit 31) set and a nonzero exponent field gives the quiet NaN 32'h7FC00000. This includes negative infinity and negative NaNs.
- R5: A positive NaN operand (exponent field all ones, nonzero fraction) gives the quiet NaN 32'h7FC00000.
- R6: Positive infinity, 32'h7F800000, gives +0, 32'h00000000.
- R7: For every positive normal operand x, the result y satisfies |y*sqrt(x) - 1| <= 0.002.
- R8: The first approximation is 32'h5F3759D5 minus the operand's bit pattern shifted right by one, and exactly one Newton step y0*(1.5 - 0.5*x*y0*y0) follows it. An operand that is 1.0 times a power of four therefore gives y*sqrt(x) between 0.9980 and 0.9986. That window rules out both the unrefined approximation and a second refinement.
- R9: Every result that is not the quiet NaN has its sign bit (bit 31) clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operand present this cycle |
| in_data | input | 32 | Single-precision operand |
| out_valid | output | 1 | Result present this cycle |
| out_data | output | 32 | Single-precision result |

## Verification
The assertions are checked on every cycle. They cover the five-cycle pairing of `out_valid` with `in_valid`, the fixed result codes for zero, denormal, negative, infinite and NaN operands, and the clear sign bit on every non-NaN result. Only the bench's scenarios can show the numerical quality. It sweeps every normal exponent against sixteen fraction patterns and compares each result with a real-valued 1/sqrt reference. For powers of four it checks the narrow window that proves one refinement step was applied, and no more.

// File: rtl/rsqrt_pkg.sv
// Package: shared float word type, field widths and constant codes for the
// reciprocal square root estimator. Assumes IEEE-754 single-precision layout.
package rsqrt_pkg;
    localparam int EXP_W = 8;
    localparam int MAN_W = 23;
    localparam int FP_W  = 1 + EXP_W + MAN_W;
    localparam int BIAS  = (1 << (EXP_W - 1)) - 1;

    typedef logic [FP_W-1:0] fp_word_t;

    localparam fp_word_t FP_POS_INF  = {1'b0, {EXP_W{1'b1}}, {MAN_W{1'b0}}};
    localparam fp_word_t FP_QNAN     = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};
    localparam fp_word_t FP_ZERO     = '0;
    localparam fp_word_t FP_ONE_HALF = {1'b0, EXP_W'(BIAS), 1'b1, {(MAN_W-1){1'b0}}};

    // Per-stage side information that travels alongside the arithmetic.
    typedef struct packed {
        logic     valid;
        logic     spec;
        fp_word_t spec_val;
        fp_word_t guess;
    } side_t;

    // Halve a float by decrementing its exponent; tiny values flush to zero.
    function automatic fp_word_t fp_halve(input fp_word_t v);
        logic [EXP_W-1:0] e;
        e = v[FP_W-2 -: EXP_W];
        if (e <= EXP_W'(1))
            fp_halve = {v[FP_W-1], {(FP_W-1){1'b0}}};
        else
            fp_halve = {v[FP_W-1], e - EXP_W'(1), v[MAN_W-1:0]};
    endfunction
endpackage

// File: rtl/rsqrt_fmul.sv
// Combinational single-precision multiplier with a truncated product.
// Assumes normal or zero operands (exponent field 0 is read as zero);
// overflow saturates to infinity and underflow flushes to zero.
module rsqrt_fmul
    import rsqrt_pkg::*;
(
    input  fp_word_t a_i,
    input  fp_word_t b_i,
    output fp_word_t p_o
);
    localparam int SIG_W  = MAN_W + 1;
    localparam int PROD_W = 2 * SIG_W;
    localparam int EXT_W  = EXP_W + 2;
    localparam logic signed [EXT_W-1:0] E_MAX  = EXT_W'((1 << EXP_W) - 1);
    localparam logic signed [EXT_W-1:0] E_NONE = '0;

    logic [EXP_W-1:0]         ea, eb;
    logic [PROD_W-1:0]        prod, norm;
    logic signed [EXT_W-1:0]  e_sum, e_n;
    logic [MAN_W-1:0]         man;
    logic                     sgn;

    // Multiply significands, normalise by at most one place, drop the low half.
    always_comb begin
        ea    = a_i[FP_W-2 -: EXP_W];
        eb    = b_i[FP_W-2 -: EXP_W];
        sgn   = a_i[FP_W-1] ^ b_i[FP_W-1];
        prod  = {{SIG_W{1'b0}}, 1'b1, a_i[MAN_W-1:0]} * {{SIG_W{1'b0}}, 1'b1, b_i[MAN_W-1:0]};
        norm  = prod[PROD_W-1] ? prod : (prod << 1);
        e_sum = $signed({2'b00, ea}) + $signed({2'b00, eb}) - $signed(EXT_W'(BIAS));
        e_n   = e_sum + $signed({{(EXT_W-1){1'b0}}, prod[PROD_W-1]});
        man   = MAN_W'(norm >> (PROD_W - 1 - MAN_W));
        if (ea == '0 || eb == '0 || e_n <= E_NONE)
            p_o = {sgn, {(FP_W-1){1'b0}}};
        else if (e_n >= E_MAX)
            p_o = {sgn, {EXP_W{1'b1}}, {MAN_W{1'b0}}};
        else
            p_o = {sgn, e_n[EXP_W-1:0], man};
    end
endmodule

// File: rtl/rsqrt_fsub.sv
// Combinational single-precision subtractor a - b for operands of equal sign.
// Aligns exponents with a truncating shift (GRD guard bits), subtracts the
// magnitudes and renormalises with a leading-zero count. Zero flushes to +0.
module rsqrt_fsub
    import rsqrt_pkg::*;
#(
    parameter int GRD = 3
) (
    input  fp_word_t a_i,
    input  fp_word_t b_i,
    output fp_word_t d_o
);
    localparam int W     = MAN_W + 1 + GRD;
    localparam int LZ_W  = $clog2(W);
    localparam int EXT_W = EXP_W + 2;
    localparam logic [EXP_W-1:0]        SH_LIM = EXP_W'(W);
    localparam logic signed [EXT_W-1:0] E_NONE = '0;

    logic                    swap, found;
    logic [EXP_W-1:0]        e_big, e_sml, diff;
    logic [W-1:0]            m_big, m_sml, m_sh, dif, norm;
    logic [LZ_W-1:0]         lz;
    logic signed [EXT_W-1:0] e_res;

    // Order by magnitude, align, subtract, then find the leading one.
    always_comb begin
        swap  = b_i[FP_W-2:0] > a_i[FP_W-2:0];
        e_big = swap ? b_i[FP_W-2 -: EXP_W] : a_i[FP_W-2 -: EXP_W];
        e_sml = swap ? a_i[FP_W-2 -: EXP_W] : b_i[FP_W-2 -: EXP_W];
        m_big = swap ? {|b_i[FP_W-2 -: EXP_W], b_i[MAN_W-1:0], {GRD{1'b0}}}
                     : {|a_i[FP_W-2 -: EXP_W], a_i[MAN_W-1:0], {GRD{1'b0}}};
        m_sml = swap ? {|a_i[FP_W-2 -: EXP_W], a_i[MAN_W-1:0], {GRD{1'b0}}}
                     : {|b_i[FP_W-2 -: EXP_W], b_i[MAN_W-1:0], {GRD{1'b0}}};
        diff  = e_big - e_sml;
        m_sh  = (diff >= SH_LIM) ? '0 : (m_sml >> diff);
        dif   = m_big - m_sh;
        lz    = '0;
        found = 1'b0;
        for (int k = W - 1; k >= 0; k--) begin
            if (!found && dif[k]) begin
                lz    = LZ_W'(W - 1 - k);
                found = 1'b1;
            end
        end
        norm  = dif << lz;
        e_res = $signed({2'b00, e_big}) - $signed({{(EXT_W-LZ_W){1'b0}}, lz});
        if (!found || e_res <= E_NONE)
            d_o = FP_ZERO;
        else
            d_o = {swap ? ~b_i[FP_W-1] : a_i[FP_W-1], e_res[EXP_W-1:0],
                   MAN_W'(norm >> GRD)};
    end
endmodule

// File: rtl/rsqrt_est.sv
// Reciprocal square root estimator, five-cycle pipeline, one operand per cycle.
// Stage 1 classifies the operand and forms the bit-level first guess; stages
// 2..5 apply one Newton step y0*(1.5 - 0.5*x*y0*y0). Halving is done on the
// product x*y0*y0 (exponent decrement) so that no intermediate underflows.
// Assumes denormals may be flushed; rounding is truncation throughout.
module rsqrt_est
    import rsqrt_pkg::*;
#(
    parameter logic [31:0] MAGIC = 32'h5F3759D5
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic [31:0] in_data,
    output logic        out_valid,
    output logic [31:0] out_data
);
    localparam int SIDE_N = 4;

    logic [EXP_W-1:0] in_exp;
    logic             in_man_nz, is_zero, is_top;
    logic             spec_c;
    fp_word_t         spec_val_c, guess_c;

    side_t    side_q [SIDE_N];
    fp_word_t x1_q, m2_q, h3_q, s4_q;
    fp_word_t m_c, p_c, s_c, y1_c;

    // Classify the operand and form the magic-constant first guess.
    always_comb begin
        in_exp     = in_data[FP_W-2 -: EXP_W];
        in_man_nz  = |in_data[MAN_W-1:0];
        is_zero    = (in_exp == '0);
        is_top     = (in_exp == {EXP_W{1'b1}});
        guess_c    = MAGIC - {1'b0, in_data[FP_W-1:1]};
        spec_c     = 1'b1;
        spec_val_c = FP_ZERO;
        if (is_zero)
            spec_val_c = FP_POS_INF;
        else if (in_data[FP_W-1] || (is_top && in_man_nz))
            spec_val_c = FP_QNAN;
        else if (is_top)
            spec_val_c = FP_ZERO;
        else
            spec_c = 1'b0;
    end

    // Stage 2: x * y0.
    rsqrt_fmul u_mul_xy (.a_i(x1_q), .b_i(side_q[0].guess), .p_o(m_c));
    // Stage 3: (x * y0) * y0, halved afterwards.
    rsqrt_fmul u_mul_xyy (.a_i(m2_q), .b_i(side_q[1].guess), .p_o(p_c));
    // Stage 4: 1.5 - 0.5*x*y0*y0.
    rsqrt_fsub u_sub (.a_i(FP_ONE_HALF), .b_i(h3_q), .d_o(s_c));
    // Stage 5: y0 * correction.
    rsqrt_fmul u_mul_out (.a_i(side_q[SIDE_N-1].guess), .b_i(s4_q), .p_o(y1_c));

    // Advance the side information (valid, bypass code, guess) each cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < SIDE_N; k++) side_q[k] <= '0;
        end else begin
            side_q[0] <= '{valid: in_valid, spec: spec_c, spec_val: spec_val_c, guess: guess_c};
            for (int k = 1; k < SIDE_N; k++) side_q[k] <= side_q[k-1];
        end
    end

    // Register the arithmetic intermediates between stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x1_q <= '0;
            m2_q <= '0;
            h3_q <= '0;
            s4_q <= '0;
        end else begin
            x1_q <= in_data;
            m2_q <= m_c;
            h3_q <= fp_halve(p_c);
            s4_q <= s_c;
        end
    end

    // Select the refined value or the bypass code into the output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= side_q[SIDE_N-1].valid;
            out_data  <= side_q[SIDE_N-1].spec ? side_q[SIDE_N-1].spec_val : y1_c;
        end
    end
endmodule

// File: rtl/rsqrt_est_chk.sv
// Checker for rsqrt_est: pipeline timing and bypass result codes.
// Bound to every instance of rsqrt_est by the bind statement below.
module rsqrt_est_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [31:0] in_data,
    input logic        out_valid,
    input logic [31:0] out_data
);
    logic [2:0] age_q;

    // Count cycles since reset so that $past never reaches before it.
    always_ff @(posedge clk) begin
        if (!rst_n)              age_q <= '0;
        else if (age_q != 3'd7)  age_q <= age_q + 3'd1;
    end

    assert_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 3'd5) |-> (out_valid == $past(in_valid, 5)));

    assert_reset_quiet_R2: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_data == 32'h0));

    assert_zero_inf_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 3'd5 && $past(in_valid, 5) && $past(in_data[30:23], 5) == 8'h00)
        |-> (out_data == 32'h7F800000));

    assert_neg_nan_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 3'd5 && $past(in_valid, 5) && $past(in_data[31], 5)
         && $past(in_data[30:23], 5) != 8'h00)
        |-> (out_data == 32'h7FC00000));

    assert_pos_nan_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 3'd5 && $past(in_valid, 5) && !$past(in_data[31], 5)
         && $past(in_data[30:23], 5) == 8'hFF && $past(in_data[22:0], 5) != 23'h0)
        |-> (out_data == 32'h7FC00000));

    assert_inf_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 3'd5 && $past(in_valid, 5) && $past(in_data, 5) == 32'h7F800000)
        |-> (out_data == 32'h0));

    assert_positive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_data != 32'h7FC00000) |-> !out_data[31]);
endmodule

bind rsqrt_est rsqrt_est_chk u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data)
);

// File: tb/rsqrt_est_tb.sv
// Bench for rsqrt_est: sweeps every normal exponent against sixteen fraction
// patterns, plus bypass codes and the one-refinement window; checks latency.
module rsqrt_est_tb;
    localparam int LAT   = 5;
    localparam int DEPTH = 8192;
    localparam int K_REF = 0;
    localparam int K_EXACT = 1;
    localparam int K_WIN = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_data = 32'h0;
    logic        out_valid;
    logic [31:0] out_data;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int wr     = 0;
    int rd     = 0;
    bit done   = 1'b0;

    logic [31:0] q_in   [DEPTH];
    logic [31:0] q_exp  [DEPTH];
    int          q_kind [DEPTH];
    int          q_cyc  [DEPTH];

    rsqrt_est u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .out_valid(out_valid), .out_data(out_data)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic real f2r(input logic [31:0] w);
        logic [63:0] d;
        d = {w[31], 11'(w[30:23]) + 11'd896, w[22:0], 29'b0};
        return $bitstoreal(d);
    endfunction

    task automatic chk(input bit ok, input string req, input string act, input string expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%s expected=%s", req, act, expv);
        end
    endtask

    task automatic send(input logic [31:0] w, input int kind, input logic [31:0] ew);
        @(negedge clk);
        in_valid  = 1'b1;
        in_data   = w;
        q_in[wr]  = w;
        q_kind[wr] = kind;
        q_exp[wr] = ew;
        q_cyc[wr] = cyc;
        wr++;
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
        in_data  = 32'hDEADBEEF;
    endtask

    // Compare each result with the scoreboard entry it belongs to.
    always @(negedge clk) begin
        if (rst_n && out_valid && !done) begin
            if (rd >= wr) begin
                chk(1'b0, "R1 unexpected out_valid", $sformatf("%h", out_data), "no output");
            end else begin
                real x, y, r;
                chk((cyc - q_cyc[rd]) == LAT, "R1 latency",
                    $sformatf("%0d", cyc - q_cyc[rd]), $sformatf("%0d", LAT));
                if (q_kind[rd] == K_EXACT) begin
                    chk(out_data == q_exp[rd], "R3/R4/R5/R6 bypass code",
                        $sformatf("%h (in %h)", out_data, q_in[rd]), $sformatf("%h", q_exp[rd]));
                end else begin
                    x = f2r(q_in[rd]);
                    y = f2r(out_data);
                    r = y * $sqrt(x);
                    if (q_kind[rd] == K_WIN)
                        chk(!out_data[31] && r >= 0.9980 && r <= 0.9986, "R8 one Newton step",
                            $sformatf("%h ratio %f", out_data, r), "ratio in [0.9980,0.9986]");
                    else
                        chk(!out_data[31] && out_data[30:23] != 8'h00 && out_data[30:23] != 8'hFF
                            && r >= 0.998 && r <= 1.002, "R7 R9 relative error",
                            $sformatf("%h ratio %f (in %h)", out_data, r, q_in[rd]), "ratio within 0.002 of 1");
                end
                rd++;
            end
        end
    end

    // Stimulus: reset behaviour, bypass codes, R8 window, then the sweep.
    initial begin
        in_valid = 1'b1;
        in_data  = 32'h3F800000;
        repeat (4) @(negedge clk);
        chk(!out_valid && out_data == 32'h0, "R2 outputs in reset",
            $sformatf("%b/%h", out_valid, out_data), "0/00000000");
        rst_n    = 1'b1;
        in_valid = 1'b0;
        repeat (LAT + 2) begin
            @(negedge clk);
            chk(!out_valid, "R2 no output from operands held during reset",
                $sformatf("%b", out_valid), "0");
        end

        send(32'h00000000, K_EXACT, 32'h7F800000);   // R3 +0
        send(32'h80000000, K_EXACT, 32'h7F800000);   // R3 -0
        send(32'h00000001, K_EXACT, 32'h7F800000);   // R3 denormal
        send(32'h807FFFFF, K_EXACT, 32'h7F800000);   // R3 negative denormal
        send(32'hBF800000, K_EXACT, 32'h7FC00000);   // R4 -1.0
        send(32'hFF800000, K_EXACT, 32'h7FC00000);   // R4 -inf
        send(32'hFFFFFFFF, K_EXACT, 32'h7FC00000);   // R4 negative NaN
        idle();
        send(32'h7FC00001, K_EXACT, 32'h7FC00000);   // R5 quiet NaN
        send(32'h7F800001, K_EXACT, 32'h7FC00000);   // R5 signalling NaN
        send(32'h7F800000, K_EXACT, 32'h00000000);   // R6 +inf
        idle();
        send(32'h3F800000, K_WIN, 32'h0);            // R8 1.0
        send(32'h40800000, K_WIN, 32'h0);            // R8 4.0
        send(32'h3E800000, K_WIN, 32'h0);            // R8 0.25
        send(32'h4F800000, K_WIN, 32'h0);            // R8 2^32

        for (int e = 1; e <= 254; e++) begin
            for (int m = 0; m < 16; m++) begin
                logic [22:0] man;
                man = (m == 15) ? 23'h7FFFFF : 23'(m * 32'h0051A2B3);
                send({1'b0, 8'(e), man}, K_REF, 32'h0);   // R7 sweep
                if ((e + m) % 7 == 0) idle();
            end
        end
        idle();
        repeat (LAT + 3) @(negedge clk);
        chk(rd == wr, "R1 every operand produced one result",
            $sformatf("%0d", rd), $sformatf("%0d", wr));
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog: a hung run is reported as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule